// File: doc/BRIEF.md
# SDRAM Command Decoder and Bank State Tracker

This block watches the command side of a double-data-rate SDRAM bus. On every rising clock edge it turns the chip-select, row-strobe, column-strobe and write-enable pins, together with the clock-enable pin, the bank-select pins and address bit 10, into one command code. It then applies that command to a model of four banks. Each bank moves through idle, activating, row-open, reading, writing, write-recovery and precharging states.

A command that the current bank states forbid is flagged as illegal for one cycle and changes no bank. A command that is allowed but comes before a minimum cycle gap has elapsed is applied, and it raises a sticky violation flag. Every gap is a run-time input counted in clock cycles. The block is meant to sit beside a memory controller or a memory model, either as a protocol monitor or as the source of bank state for a scheduler.

Top module: `sdram_cmd_tracker`

## Requirements
- R1: The command is decoded at each rising edge, and `cmd_o` shows its code after that edge. With clock enable high in both the previous and current cycle:
  - chip select high gives DESL=0.
  - With chip select low, the row/column/write strobes decode as follows: 111 is NOP=1, 110 is BST=2, 101 is RD=3, 100 is WR=5, 011 is ACT=7, 010 is PRE=8, 001 is REF=10 and 000 is MRS=11.
- R2: Address bit 10 changes three codes. It turns RD into RDA=4 and WR into WRA=6. It turns PRE into PALL=9, which targets every bank; PRE with bit 10 low targets only the bank on `ba`.
- R3: With the mode pattern, `ba[0]` high gives EMRS=12 and `ba[0]` low gives MRS=11. MRS, EMRS and REF are illegal unless every bank is idle.
- R4: ACT to a bank that is not idle is illegal. An illegal command pulses `illegal_o` for one cycle and leaves every bank state unchanged. Bank state codes are IDLE=0, ACTIVATING=1, OPEN=2, READ=3, WRITE=4, WRECOVER=5 and PRECHARGING=6.
- R5: RD, WR, ACT or PRE/PALL to a bank that is still activating or still precharging is illegal.
- R6: A bank accepts RD or WR exactly `cfg_rcd` cycles after its ACT. A bank accepts ACT again exactly `cfg_rp` cycles after its precharge.
- R7: Three gaps set bit b of the sticky `timing_viol_o` when they are broken:
  - a legal precharge to bank b sooner than `cfg_ras` cycles after its ACT, or while its write recovery is running;
  - an ACT to bank b sooner than `cfg_rc` cycles after its previous ACT;
  - an ACT sooner than `cfg_rrd` cycles after an ACT to any bank.
- R8: Any command other than DESL, NOP, EXIT or HOLD that comes sooner than `cfg_rfc` cycles after REF, or sooner than `cfg_mrd` cycles after MRS/EMRS, sets the sticky `gap_viol_o`.
- R9: After RDA the bank stays READ for `cfg_bl` cycles, then precharges for `cfg_rp` cycles and becomes idle. After WRA the bank stays WRITE for `cfg_bl` cycles, then WRECOVER for `cfg_wr` cycles, then precharges.
- R10: Clock enable changes what is decoded:
  - A fall of clock enable gives SLEEP=13. It is illegal unless all banks are idle and the pins show DESL, NOP or REF.
  - While clock enable stays low, the code is HOLD=15 and the pins have no effect.
  - A rise of clock enable gives EXIT=14. It is illegal unless the pins show DESL or NOP.
- R11: Synchronous reset sets every bank to IDLE and clears all flags. It sets `cmd_o` to 0 and treats clock enable as previously low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command clock |
| rst | input | 1 | Synchronous active-high reset |
| cke | input | 1 | Clock-enable pin |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | BAW | Bank select |
| a10 | input | 1 | Address bit 10 (auto-precharge / all banks) |
| cfg_rcd | input | TW | Activate-to-access gap |
| cfg_rp | input | TW | Precharge duration |
| cfg_ras | input | TW | Activate-to-precharge minimum |
| cfg_rc | input | TW | Activate-to-activate, same bank |
| cfg_rrd | input | TW | Activate-to-activate, any bank |
| cfg_rfc | input | TW | Refresh busy time |
| cfg_mrd | input | TW | Mode-register busy time |
| cfg_wr | input | TW | Write recovery time |
| cfg_bl | input | TW | Burst length in clock cycles |
| cmd_o | output | 4 | Decoded command code |
| illegal_o | output | 1 | Pulse: last command was illegal |
| bank_state_o | output | 3*NB | State code per bank, bank 0 in the low bits |
| timing_viol_o | output | NB | Sticky per-bank gap violation |
| gap_viol_o | output | 1 | Sticky refresh/mode gap violation |

## Verification
The assertions assume that every `cfg_*` input is at least 1 and does not change after reset. They also assume that the inputs are stable around the clock edge.

The bench programs one fixed set of gaps: 3, 3, 8, 11, 2, 14, 2 and 3, with a burst of 2 cycles. It changes the pins only at falling edges. Every scenario starts from a fresh reset, so the expected state of each sweep point follows from the requirements alone.

// File: rtl/sdcmd_pkg.sv
package sdcmd_pkg;
  typedef enum logic [3:0] {
    C_DESL = 4'd0, C_NOP = 4'd1, C_BST = 4'd2, C_RD = 4'd3,
    C_RDA = 4'd4, C_WR = 4'd5, C_WRA = 4'd6, C_ACT = 4'd7,
    C_PRE = 4'd8, C_PALL = 4'd9, C_REF = 4'd10, C_MRS = 4'd11,
    C_EMRS = 4'd12, C_SLEEP = 4'd13, C_EXIT = 4'd14, C_HOLD = 4'd15
  } cmd_e;

  typedef enum logic [2:0] {
    B_IDLE = 3'd0, B_ACTG = 3'd1, B_OPEN = 3'd2, B_RD = 3'd3,
    B_WR = 3'd4, B_WREC = 3'd5, B_PRE = 3'd6
  } bst_e;
endpackage

// File: rtl/sdcmd_decode.sv
module sdcmd_decode
  import sdcmd_pkg::*;
(
  input  logic cke,
  input  logic cke_q,
  input  logic cs_n,
  input  logic ras_n,
  input  logic cas_n,
  input  logic we_n,
  input  logic ba0,
  input  logic a10,
  output cmd_e cmd,
  output logic exit_bad,
  output logic sleep_bad
);
  logic [2:0] pins;
  logic       quiet_pat;

  always_comb begin
    pins      = {ras_n, cas_n, we_n};
    quiet_pat = cs_n || (pins == 3'b111);
    cmd       = C_DESL;
    exit_bad  = 1'b0;
    sleep_bad = 1'b0;
    if (!cke_q && !cke) begin
      cmd = C_HOLD;
    end else if (!cke_q) begin
      cmd      = C_EXIT;
      exit_bad = !quiet_pat;
    end else if (!cke) begin
      cmd       = C_SLEEP;
      sleep_bad = !(quiet_pat || pins == 3'b001);
    end else if (!cs_n) begin
      case (pins)
        3'b111:  cmd = C_NOP;
        3'b110:  cmd = C_BST;
        3'b101:  cmd = a10 ? C_RDA : C_RD;
        3'b100:  cmd = a10 ? C_WRA : C_WR;
        3'b011:  cmd = C_ACT;
        3'b010:  cmd = a10 ? C_PALL : C_PRE;
        3'b001:  cmd = C_REF;
        default: cmd = ba0 ? C_EMRS : C_MRS;
      endcase
    end
  end
endmodule

// File: rtl/sdcmd_bank.sv
module sdcmd_bank
  import sdcmd_pkg::*;
#(
  parameter int TW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  cmd_e          cmd,
  input  logic          sel,
  input  logic          acc,
  input  logic [TW-1:0] t_rcd,
  input  logic [TW-1:0] t_rp,
  input  logic [TW-1:0] t_ras,
  input  logic [TW-1:0] t_rc,
  input  logic [TW-1:0] t_wr,
  input  logic [TW-1:0] t_bl,
  output bst_e          st,
  output logic          local_ill,
  output logic          local_tv
);
  logic [TW-1:0] ph, ras_left, rc_left;
  logic          ap;
  bst_e          eff;
  logic          open_row, apply;

  function automatic logic [TW-1:0] ld(input logic [TW-1:0] g);
    return (g == '0) ? '0 : g - 1'b1;
  endfunction

  always_comb begin
    eff = st;
    if (ph == '0 && st == B_ACTG) eff = B_OPEN;
    if (ph == '0 && st == B_PRE)  eff = B_IDLE;
    open_row  = eff inside {B_OPEN, B_RD, B_WR, B_WREC};
    local_ill = 1'b0;
    local_tv  = 1'b0;
    if (sel) begin
      case (cmd)
        C_ACT: begin
          local_ill = (eff != B_IDLE);
          local_tv  = (rc_left != '0);
        end
        C_RD, C_RDA, C_WR, C_WRA: local_ill = !open_row || ap;
        C_PRE, C_PALL: begin
          local_ill = (eff == B_ACTG) || (eff == B_PRE) || ap;
          local_tv  = (eff != B_IDLE) &&
                      ((ras_left != '0) || (st == B_WREC && ph != '0));
        end
        C_REF, C_MRS, C_EMRS, C_SLEEP: local_ill = (eff != B_IDLE);
        default: ;
      endcase
    end
  end

  assign apply = acc && sel;

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= B_IDLE;
      ph       <= '0;
      ras_left <= '0;
      rc_left  <= '0;
      ap       <= 1'b0;
    end else begin
      if (ras_left != '0) ras_left <= ras_left - 1'b1;
      if (rc_left != '0)  rc_left  <= rc_left - 1'b1;
      if (ph != '0)       ph       <= ph - 1'b1;
      if (apply && cmd == C_ACT) begin
        st       <= B_ACTG;
        ph       <= ld(t_rcd);
        ras_left <= ld(t_ras);
        rc_left  <= ld(t_rc);
      end else if (apply && cmd inside {C_RD, C_RDA, C_WR, C_WRA}) begin
        st <= (cmd inside {C_RD, C_RDA}) ? B_RD : B_WR;
        ph <= ld(t_bl);
        ap <= (cmd == C_RDA) || (cmd == C_WRA);
      end else if (apply && cmd inside {C_PRE, C_PALL} && eff != B_IDLE) begin
        st <= B_PRE;
        ph <= ld(t_rp);
      end else if (ph == '0) begin
        case (st)
          B_ACTG: st <= B_OPEN;
          B_RD, B_WREC: begin
            if (ap) begin
              st <= B_PRE;
              ph <= ld(t_rp);
              ap <= 1'b0;
            end else begin
              st <= B_OPEN;
            end
          end
          B_WR: begin
            st <= B_WREC;
            ph <= ld(t_wr);
          end
          B_PRE: st <= B_IDLE;
          default: ;
        endcase
      end
    end
  end

  // R5: a precharging bank that has not finished only counts down
  a_r5_prech_counts: assert property (@(posedge clk) disable iff (rst)
    (st == B_PRE && ph != '0) |=> (st == B_PRE && ph == $past(ph) - 1'b1));
  // R6: an activating bank whose gap has run out is usable on the next cycle
  a_r6_act_ready: assert property (@(posedge clk) disable iff (rst)
    (st == B_ACTG && ph == '0) |=> (st inside {B_OPEN, B_RD, B_WR, B_PRE}));
  // R9: write recovery with auto-precharge always ends in precharge
  a_r9_ap_close: assert property (@(posedge clk) disable iff (rst)
    (st == B_WREC && ph == '0 && ap) |=> (st == B_PRE));
  // R11: reset leaves the bank idle
  a_r11_reset_idle: assert property (@(posedge clk)
    rst |=> (st == B_IDLE && ph == '0));
endmodule

// File: rtl/sdram_cmd_tracker.sv
module sdram_cmd_tracker
  import sdcmd_pkg::*;
#(
  parameter int NB = 4,
  parameter int TW = 6,
  localparam int BAW = $clog2(NB)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cke,
  input  logic            cs_n,
  input  logic            ras_n,
  input  logic            cas_n,
  input  logic            we_n,
  input  logic [BAW-1:0]  ba,
  input  logic            a10,
  input  logic [TW-1:0]   cfg_rcd,
  input  logic [TW-1:0]   cfg_rp,
  input  logic [TW-1:0]   cfg_ras,
  input  logic [TW-1:0]   cfg_rc,
  input  logic [TW-1:0]   cfg_rrd,
  input  logic [TW-1:0]   cfg_rfc,
  input  logic [TW-1:0]   cfg_mrd,
  input  logic [TW-1:0]   cfg_wr,
  input  logic [TW-1:0]   cfg_bl,
  output logic [3:0]      cmd_o,
  output logic            illegal_o,
  output logic [3*NB-1:0] bank_state_o,
  output logic [NB-1:0]   timing_viol_o,
  output logic            gap_viol_o
);
  logic          cke_q;
  cmd_e          cmd;
  logic          exit_bad, sleep_bad;
  logic [NB-1:0] sel, lill, ltv, tv_set;
  logic          all_cmd, bank_cmd, illegal, acc, quiet;
  logic [TW-1:0] rrd_left, glob_left;

  function automatic logic [TW-1:0] ld(input logic [TW-1:0] g);
    return (g == '0) ? '0 : g - 1'b1;
  endfunction

  sdcmd_decode u_dec (
    .cke(cke), .cke_q(cke_q), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .ba0(ba[0]), .a10(a10), .cmd(cmd),
    .exit_bad(exit_bad), .sleep_bad(sleep_bad)
  );

  assign all_cmd  = cmd inside {C_PALL, C_REF, C_MRS, C_EMRS, C_SLEEP};
  assign bank_cmd = cmd inside {C_RD, C_RDA, C_WR, C_WRA, C_ACT, C_PRE};
  assign illegal  = (|(sel & lill)) || exit_bad || sleep_bad;
  assign acc      = !illegal;
  assign quiet    = cmd inside {C_DESL, C_NOP, C_EXIT, C_HOLD};

  for (genvar b = 0; b < NB; b++) begin : g_bank
    bst_e st_b;
    assign sel[b] = all_cmd || (bank_cmd && ba == BAW'(b));
    sdcmd_bank #(.TW(TW)) u_bank (
      .clk(clk), .rst(rst), .cmd(cmd), .sel(sel[b]), .acc(acc),
      .t_rcd(cfg_rcd), .t_rp(cfg_rp), .t_ras(cfg_ras), .t_rc(cfg_rc),
      .t_wr(cfg_wr), .t_bl(cfg_bl), .st(st_b),
      .local_ill(lill[b]), .local_tv(ltv[b])
    );
    assign bank_state_o[3*b +: 3] = st_b;
    assign tv_set[b] = acc && sel[b] &&
                       (ltv[b] || (cmd == C_ACT && rrd_left != '0));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cke_q         <= 1'b0;
      cmd_o         <= C_DESL;
      illegal_o     <= 1'b0;
      timing_viol_o <= '0;
      gap_viol_o    <= 1'b0;
      rrd_left      <= '0;
      glob_left     <= '0;
    end else begin
      cke_q         <= cke;
      cmd_o         <= cmd;
      illegal_o     <= illegal;
      timing_viol_o <= timing_viol_o | tv_set;
      if (acc && !quiet && glob_left != '0) gap_viol_o <= 1'b1;
      if (rrd_left != '0)  rrd_left  <= rrd_left - 1'b1;
      if (glob_left != '0) glob_left <= glob_left - 1'b1;
      if (acc && cmd == C_ACT) rrd_left <= ld(cfg_rrd);
      if (acc && cmd == C_REF) glob_left <= ld(cfg_rfc);
      else if (acc && cmd inside {C_MRS, C_EMRS}) glob_left <= ld(cfg_mrd);
    end
  end

  // R10: while clock enable stays low the pins are not decoded
  a_r10_hold_quiet: assert property (@(posedge clk) disable iff (rst)
    (!cke_q && !cke) |=> (cmd_o == C_HOLD && !illegal_o));
  // R3: an accepted refresh leaves every bank idle
  a_r3_ref_idle: assert property (@(posedge clk) disable iff (rst)
    (cmd == C_REF && acc) |=> (bank_state_o == '0));
  // R7: per-bank gap flags never clear
  a_r7_sticky: assert property (@(posedge clk) disable iff (rst)
    (timing_viol_o != '0) |=>
      ((timing_viol_o & $past(timing_viol_o)) == $past(timing_viol_o)));
  // R8: the refresh/mode gap flag never clears
  a_r8_sticky: assert property (@(posedge clk) disable iff (rst)
    gap_viol_o |=> gap_viol_o);
endmodule

// File: tb/sdram_cmd_tracker_bench.sv
module sdram_cmd_tracker_bench;
  localparam logic [3:0] P_NOP = 4'b0111, P_DES = 4'b1111, P_ACT = 4'b0011,
                         P_RD = 4'b0101, P_WR = 4'b0100, P_PRE = 4'b0010,
                         P_REF = 4'b0001, P_MRS = 4'b0000;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst = 1'b1, cke = 1'b1, cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic [1:0] ba = 2'd0;
  logic a10 = 1'b0;
  logic [3:0] cmd_o;
  logic illegal_o, gap_viol_o;
  logic [11:0] bank_state_o;
  logic [3:0] timing_viol_o;
  int vectors = 0, miscomp = 0;

  sdram_cmd_tracker u_sdram_cmd_tracker (
    .clk(clk), .rst(rst), .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .ba(ba), .a10(a10),
    .cfg_rcd(6'd3), .cfg_rp(6'd3), .cfg_ras(6'd8), .cfg_rc(6'd11),
    .cfg_rrd(6'd2), .cfg_rfc(6'd14), .cfg_mrd(6'd2), .cfg_wr(6'd3), .cfg_bl(6'd2),
    .cmd_o(cmd_o), .illegal_o(illegal_o), .bank_state_o(bank_state_o),
    .timing_viol_o(timing_viol_o), .gap_viol_o(gap_viol_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscomp++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic drive(input logic k, input logic [3:0] p, input logic [1:0] b, input logic a);
    @(negedge clk);
    cke = k; {cs_n, ras_n, cas_n, we_n} = p; ba = b; a10 = a;
    @(posedge clk); #1;
  endtask

  task automatic nops(input int n);
    for (int i = 0; i < n; i++) drive(1'b1, P_NOP, 2'd0, 1'b0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; cke = 1'b1; {cs_n, ras_n, cas_n, we_n} = P_NOP; ba = 2'd0; a10 = 1'b0;
    @(posedge clk); @(posedge clk); @(negedge clk);
    rst = 1'b0;
    @(posedge clk); #1;
  endtask

  function automatic int bst(input int b);
    return int'(bank_state_o[3*b +: 3]);
  endfunction

  function automatic int exp_code(input logic [3:0] p, input logic a, input logic b0);
    if (p[3]) return 0;
    case (p[2:0])
      3'b111: return 1;
      3'b110: return 2;
      3'b101: return a ? 4 : 3;
      3'b100: return a ? 6 : 5;
      3'b011: return 7;
      3'b010: return a ? 9 : 8;
      3'b001: return 10;
      default: return b0 ? 12 : 11;
    endcase
  endfunction

  initial begin
    #(4 * 200000);
    miscomp++;
    $display("FAIL watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscomp);
    $finish;
  end

  initial begin
    // R11: reset state
    @(posedge clk); @(posedge clk); #1;
    chk("R11 cmd", int'(cmd_o), 0);
    chk("R11 state", int'(bank_state_o), 0);
    chk("R11 flags", int'({illegal_o, gap_viol_o, timing_viol_o}), 0);
    @(negedge clk); rst = 1'b0;
    @(posedge clk); #1;
    chk("R10 exit after reset", int'(cmd_o), 14);

    // R1 R2 R3: full pin sweep from the all-idle state
    for (int p = 0; p < 16; p++)
      for (int a = 0; a < 2; a++)
        for (int b = 0; b < 2; b++) begin
          do_reset();
          drive(1'b1, 4'(p), {1'b0, 1'(b)}, 1'(a));
          chk("R1 code", int'(cmd_o), exp_code(4'(p), 1'(a), 1'(b)));
          chk("R5 access to idle bank",
              int'(illegal_o), int'(p < 8 && (p[2:0] == 3'b101 || p[2:0] == 3'b100)));
        end

    // R6 R5: activate-to-read gap sweep
    for (int g = 1; g <= 6; g++) begin
      do_reset();
      drive(1'b1, P_ACT, 2'd0, 1'b0);
      nops(g - 1);
      drive(1'b1, P_RD, 2'd0, 1'b0);
      chk("R5 read while activating", int'(illegal_o), int'(g < 3));
      chk("R6 read gap state", bst(0), (g < 3) ? 1 : 3);
    end

    // R7: activate-to-precharge gap sweep
    for (int g = 1; g <= 10; g++) begin
      do_reset();
      drive(1'b1, P_ACT, 2'd0, 1'b0);
      nops(g - 1);
      drive(1'b1, P_PRE, 2'd0, 1'b0);
      chk("R5 precharge while activating", int'(illegal_o), int'(g < 3));
      chk("R7 ras violation", int'(timing_viol_o), (g >= 3 && g < 8) ? 1 : 0);
      chk("R7 precharge state", bst(0), (g < 3) ? 1 : 6);
    end

    // R6: precharge-to-activate gap sweep
    for (int m = 1; m <= 5; m++) begin
      do_reset();
      drive(1'b1, P_ACT, 2'd0, 1'b0);
      nops(7);
      drive(1'b1, P_PRE, 2'd0, 1'b0);
      nops(m - 1);
      drive(1'b1, P_ACT, 2'd0, 1'b0);
      chk("R6 act while precharging", int'(illegal_o), int'(m < 3));
      chk("R6 reactivate state", bst(0), (m < 3) ? 6 : 1);
      chk("R7 no violation", int'(timing_viol_o), 0);
    end

    // R7: bank-to-bank activate gap
    for (int g = 1; g <= 3; g++) begin
      do_reset();
      drive(1'b1, P_ACT, 2'd0, 1'b0);
      nops(g - 1);
      drive(1'b1, P_ACT, 2'd1, 1'b0);
      chk("R7 rrd flag", int'(timing_viol_o), (g < 2) ? 2 : 0);
      chk("R7 rrd state", bst(1), 1);
    end

    // R4 R3: commands against an open bank
    do_reset();
    drive(1'b1, P_ACT, 2'd0, 1'b0);
    nops(4);
    drive(1'b1, P_ACT, 2'd0, 1'b0);
    chk("R4 act to open bank", int'(illegal_o), 1);
    chk("R4 state kept", bst(0), 2);
    drive(1'b1, P_REF, 2'd0, 1'b0);
    chk("R3 refresh with open bank", int'(illegal_o), 1);
    drive(1'b1, P_MRS, 2'd0, 1'b0);
    chk("R3 mode set with open bank", int'(illegal_o), 1);

    // R2: single-bank and all-bank precharge
    do_reset();
    drive(1'b1, P_ACT, 2'd0, 1'b0);
    nops(1);
    drive(1'b1, P_ACT, 2'd1, 1'b0);
    nops(7);
    drive(1'b1, P_PRE, 2'd0, 1'b0);
    chk("R2 single bank0", bst(0), 6);
    chk("R2 single bank1", bst(1), 2);
    do_reset();
    drive(1'b1, P_ACT, 2'd0, 1'b0);
    nops(1);
    drive(1'b1, P_ACT, 2'd1, 1'b0);
    nops(7);
    drive(1'b1, P_PRE, 2'd3, 1'b1);
    chk("R2 all code", int'(cmd_o), 9);
    chk("R2 all states", int'(bank_state_o), 12'h036);
    chk("R2 all no violation", int'(timing_viol_o), 0);

    // R8: mode and refresh gaps
    do_reset();
    drive(1'b1, P_MRS, 2'd1, 1'b0);
    chk("R3 extended mode code", int'(cmd_o), 12);
    drive(1'b1, P_REF, 2'd0, 1'b0);
    chk("R8 mode gap", int'(gap_viol_o), 1);
    for (int g = 13; g <= 14; g++) begin
      do_reset();
      drive(1'b1, P_REF, 2'd0, 1'b0);
      nops(g - 1);
      drive(1'b1, P_ACT, 2'd0, 1'b0);
      chk("R8 refresh gap", int'(gap_viol_o), int'(g < 14));
    end

    // R9: auto-precharge after read and after write
    do_reset();
    drive(1'b1, P_ACT, 2'd2, 1'b0);
    nops(2);
    drive(1'b1, P_RD, 2'd2, 1'b1);
    chk("R9 read burst", bst(2), 3);
    nops(1); chk("R9 read burst end", bst(2), 3);
    nops(1); chk("R9 read to precharge", bst(2), 6);
    nops(2); chk("R9 read still precharging", bst(2), 6);
    nops(1); chk("R9 read idle", bst(2), 0);
    do_reset();
    drive(1'b1, P_ACT, 2'd2, 1'b0);
    nops(2);
    drive(1'b1, P_WR, 2'd2, 1'b1);
    chk("R9 write burst", bst(2), 4);
    nops(2); chk("R9 write recovery", bst(2), 5);
    nops(3); chk("R9 write to precharge", bst(2), 6);
    nops(3); chk("R9 write idle", bst(2), 0);

    // R10: clock enable handling
    do_reset();
    drive(1'b1, P_ACT, 2'd0, 1'b0);
    drive(1'b0, P_NOP, 2'd0, 1'b0);
    chk("R10 sleep code", int'(cmd_o), 13);
    chk("R10 sleep with open bank", int'(illegal_o), 1);
    drive(1'b0, P_ACT, 2'd1, 1'b0);
    chk("R10 hold code", int'(cmd_o), 15);
    chk("R10 hold no illegal", int'(illegal_o), 0);
    chk("R10 hold ignores act", bst(1), 0);
    drive(1'b1, P_ACT, 2'd1, 1'b0);
    chk("R10 exit code", int'(cmd_o), 14);
    chk("R10 exit with act", int'(illegal_o), 1);
    chk("R10 exit ignores act", bst(1), 0);
    do_reset();
    drive(1'b0, P_REF, 2'd0, 1'b0);
    chk("R10 sleep from idle", int'(illegal_o), 0);
    drive(1'b1, P_DES, 2'd0, 1'b0);
    chk("R10 exit deselect", int'(illegal_o), 0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscomp);
    $finish;
  end
endmodule